// File: doc/BRIEF.md
# Two-Phase Register File with Byte-Merge Writes

This block is the general-purpose register store of a processor in which each instruction takes two clock cycles: a first phase (P1) followed by a second phase (P2). It holds eight 15-bit registers and has two read ports, A and B, and one write port. Operands are read in P1. The result is committed in P2. An instruction can therefore read a register and overwrite it in the same instruction period without any forwarding logic.

A write can replace the whole word, only the low byte, or only the upper seven bits. For a partial write, the bits that are not replaced come from the word that port B captured during P1. Port B presents that word split into an upper field and a lower field. The instruction decoder is expected to point port B at the destination register whenever it issues a partial write. The decoding that decides which ports an instruction enables is done elsewhere.

A phase input tells the block which half of the instruction period the current cycle belongs to. The reset input is asserted asynchronously and released in step with the clock.

Top module: `phase_regfile`

## Requirements
- R1: Once reset has been applied, every register holds 0, and both read ports output 0 until a read captures other data.
- R2: In a P1 cycle (`ph2`=0) with a read port enabled, the port's output takes the value of the addressed register at the clock edge that ends that cycle.
- R3: Read outputs change only at the edge that ends a P1 cycle. A write committed in the P2 half of an instruction does not change that instruction's operands, and the next P1 read returns the new value.
- R4: A read port that is disabled during a P1 cycle outputs 0 after that cycle's closing edge.
- R5: Registers change only at the edge that ends a P2 cycle (`ph2`=1). Write inputs presented during P1 have no effect.
- R6: Write mode code 2'b00 leaves every register unchanged.
- R7: Write mode code 2'b11 replaces all 15 bits of the addressed register with `wr_data`.
- R8: Write mode code 2'b01 replaces bits 7:0 of the addressed register with `wr_data[7:0]` and sets bits 14:8 to the `rdb_hi` value captured in the same instruction's P1.
- R9: Write mode code 2'b10 replaces bits 14:8 with `wr_data[14:8]` and sets bits 7:0 to the captured `rdb_lo` value.
- R10: If port B was disabled in P1, a partial write fills the bits it does not replace with zeros.
- R11: `rdb_hi` carries bits 14:8 of the word port B read, and `rdb_lo` carries bits 7:0.
- R12: All eight addresses are independent storage locations, and writing one address leaves the other seven unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ph2 | input | 1 | 0 in a P1 cycle, 1 in a P2 cycle |
| rda_en | input | 1 | Read enable for port A |
| rda_addr | input | 3 | Register address for port A |
| rdb_en | input | 1 | Read enable for port B |
| rdb_addr | input | 3 | Register address for port B |
| wr_mode | input | 2 | Write mode: 00 none, 01 low byte, 10 upper bits, 11 full word |
| wr_addr | input | 3 | Destination register address |
| wr_data | input | 15 | Value to write |
| rda_data | output | 15 | Word captured by port A |
| rdb_hi | output | 7 | Bits 14:8 of the word captured by port B |
| rdb_lo | output | 8 | Bits 7:0 of the word captured by port B |

## Verification
Read results appear one edge after the P1 cycle that requests them. The monitor samples them at the falling edge that follows that rising edge. At the next falling edge, after the P2 edge, it samples them again to confirm they have not moved. A write becomes visible only at the P2 edge, so its effect is checked through a read issued in a later instruction, which delivers its data one edge after that instruction's P1 cycle. The expected value for each partial write is built from the reference model's port B word for that same instruction, so the merge rule is checked on the bits that are not replaced.

// File: rtl/pr_pkg.sv
package pr_pkg;
  typedef enum logic [1:0] {
    WM_NONE = 2'b00,
    WM_LOW  = 2'b01,
    WM_HIGH = 2'b10,
    WM_FULL = 2'b11
  } wmode_e;
endpackage

// File: rtl/pr_rst_sync.sv
module pr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/pr_storage.sv
module pr_storage #(
  parameter int W  = 15,
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0] wdata,
  output logic [N*W-1:0] regs_flat
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_ent
      logic         ent_ce;
      logic [W-1:0] ent_q;
      logic [W-1:0] ent_d;

      always_comb begin
        ent_ce = commit && (addr == AW'(gi));
        ent_d  = ent_ce ? wdata : ent_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
      end

      assign regs_flat[gi*W +: W] = ent_q;
    end
  endgenerate
endmodule

// File: rtl/pr_read_port.sv
module pr_read_port #(
  parameter int W  = 15,
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic           en,
  input  logic [AW-1:0]  addr,
  input  logic [N*W-1:0] regs_flat,
  output logic [W-1:0]   q
);
  logic [W-1:0] sel_word;
  logic [W-1:0] q_d;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < N; i++) begin
      if (addr == AW'(i)) sel_word = regs_flat[i*W +: W];
    end
  end

  always_comb begin
    q_d = q;
    if (capture) q_d = en ? sel_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/pr_write_merge.sv
module pr_write_merge
  import pr_pkg::*;
#(
  parameter int W     = 15,
  parameter int LOW_W = 8
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] keep_word,
  output logic         wr_any,
  output logic [W-1:0] merged
);
  localparam int HIGH_W = W - LOW_W;

  wmode_e m;

  always_comb begin
    m = wmode_e'(mode);
    wr_any = (m != WM_NONE);
    unique case (m)
      WM_LOW:  merged = {keep_word[W-1 -: HIGH_W], wr_data[LOW_W-1:0]};
      WM_HIGH: merged = {wr_data[W-1 -: HIGH_W], keep_word[LOW_W-1:0]};
      WM_FULL: merged = wr_data;
      default: merged = keep_word;
    endcase
  end
endmodule

// File: rtl/phase_regfile.sv
module phase_regfile #(
  parameter int W     = 15,
  parameter int N     = 8,
  parameter int LOW_W = 8,
  parameter int AW    = $clog2(N),
  parameter int HIGH_W = W - LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph2,
  input  logic              rda_en,
  input  logic [AW-1:0]     rda_addr,
  input  logic              rdb_en,
  input  logic [AW-1:0]     rdb_addr,
  input  logic [1:0]        wr_mode,
  input  logic [AW-1:0]     wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rda_data,
  output logic [HIGH_W-1:0] rdb_hi,
  output logic [LOW_W-1:0]  rdb_lo
);
  logic           rst_q_n;
  logic [N*W-1:0] regs_flat;
  logic [W-1:0]   rdb_word;
  logic [W-1:0]   merged;
  logic           wr_any;
  logic           commit;
  logic           capture;

  pr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  always_comb begin
    capture = !ph2;
    commit  = ph2 && wr_any;
  end

  pr_read_port #(.W(W), .N(N), .AW(AW)) u_rda (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .capture   (capture),
    .en        (rda_en),
    .addr      (rda_addr),
    .regs_flat (regs_flat),
    .q         (rda_data)
  );

  pr_read_port #(.W(W), .N(N), .AW(AW)) u_rdb (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .capture   (capture),
    .en        (rdb_en),
    .addr      (rdb_addr),
    .regs_flat (regs_flat),
    .q         (rdb_word)
  );

  pr_write_merge #(.W(W), .LOW_W(LOW_W)) u_merge (
    .mode      (wr_mode),
    .wr_data   (wr_data),
    .keep_word (rdb_word),
    .wr_any    (wr_any),
    .merged    (merged)
  );

  pr_storage #(.W(W), .N(N), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .commit    (commit),
    .addr      (wr_addr),
    .wdata     (merged),
    .regs_flat (regs_flat)
  );

  assign rdb_hi = rdb_word[W-1 -: HIGH_W];
  assign rdb_lo = rdb_word[LOW_W-1:0];
endmodule

// File: rtl/phase_regfile_chk.sv
module phase_regfile_chk #(
  parameter int W      = 15,
  parameter int N      = 8,
  parameter int LOW_W  = 8,
  parameter int AW     = 3,
  parameter int HIGH_W = 7
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              ph2,
  input logic              rda_en,
  input logic              rdb_en,
  input logic [1:0]        wr_mode,
  input logic [AW-1:0]     wr_addr,
  input logic [W-1:0]      wr_data,
  input logic [W-1:0]      rda_data,
  input logic [HIGH_W-1:0] rdb_hi,
  input logic [LOW_W-1:0]  rdb_lo,
  input logic [N*W-1:0]    regs_flat
);
  always @(posedge clk) begin
    if (!rst_q_n) begin
      AST_RESET_ZERO: assert (regs_flat == '0 && rda_data == '0); // R1
    end
  end

  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_q_n)
    ph2 |=> $stable(rda_data)); // R3
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_q_n)
    ph2 |=> ($stable(rdb_hi) && $stable(rdb_lo))); // R3
  AST_DIS_A: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ph2 && !rda_en) |=> (rda_data == '0)); // R4
  AST_DIS_B: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ph2 && !rdb_en) |=> (rdb_hi == '0 && rdb_lo == '0)); // R4
  AST_P1_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ph2 |=> $stable(regs_flat)); // R5
  AST_MODE_NONE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_mode == 2'b00) |=> $stable(regs_flat)); // R6
  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ph2 && wr_mode == 2'b11) |=>
      (regs_flat[int'($past(wr_addr))*W +: W] == $past(wr_data))); // R7
  AST_LOW_MERGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ph2 && wr_mode == 2'b01) |=>
      (regs_flat[int'($past(wr_addr))*W +: W] ==
        {$past(rdb_hi), $past(wr_data[LOW_W-1:0])})); // R8
  AST_HIGH_MERGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ph2 && wr_mode == 2'b10) |=>
      (regs_flat[int'($past(wr_addr))*W +: W] ==
        {$past(wr_data[W-1 -: HIGH_W]), $past(rdb_lo)})); // R9
endmodule

bind phase_regfile phase_regfile_chk #(
  .W(W), .N(N), .LOW_W(LOW_W), .AW(AW), .HIGH_W(HIGH_W)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .ph2       (ph2),
  .rda_en    (rda_en),
  .rdb_en    (rdb_en),
  .wr_mode   (wr_mode),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rda_data  (rda_data),
  .rdb_hi    (rdb_hi),
  .rdb_lo    (rdb_lo),
  .regs_flat (regs_flat)
);

// File: tb/tb_phase_regfile.sv
`timescale 1ns/1ps
module tb_phase_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        ph2 = 1'b0;
  logic        rda_en = 1'b0, rdb_en = 1'b0;
  logic [2:0]  rda_addr = '0, rdb_addr = '0, wr_addr = '0;
  logic [1:0]  wr_mode = '0;
  logic [14:0] wr_data = '0;
  logic [14:0] rda_data;
  logic [6:0]  rdb_hi;
  logic [7:0]  rdb_lo;

  int n_tests = 0;
  int n_fail  = 0;

  logic [14:0] ref_mem [8];
  logic [14:0] qa[$];
  logic [14:0] qb[$];
  string       qt[$];

  always #2.5 clk = ~clk;

  phase_regfile dut (
    .clk(clk), .rst_n(rst_n), .ph2(ph2),
    .rda_en(rda_en), .rda_addr(rda_addr),
    .rdb_en(rdb_en), .rdb_addr(rdb_addr),
    .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
    .rda_data(rda_data), .rdb_hi(rdb_hi), .rdb_lo(rdb_lo)
  );

  task automatic check(string tag, logic [14:0] act, logic [14:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One instruction: P1 cycle then P2 cycle, called at a falling edge.
  task automatic instr(input logic ea, input logic [2:0] aa,
                       input logic eb, input logic [2:0] ab,
                       input logic [1:0] mode, input logic [2:0] wa,
                       input logic [14:0] wd, input logic p1_noise,
                       input string tag);
    logic [14:0] xa, xb, nv;
    rda_en = ea; rda_addr = aa; rdb_en = eb; rdb_addr = ab; ph2 = 1'b0;
    if (p1_noise) begin
      wr_mode = 2'b11; wr_addr = wa; wr_data = ~wd;
    end else begin
      wr_mode = 2'b00;
    end
    xa = ea ? ref_mem[aa] : 15'h0;
    xb = eb ? ref_mem[ab] : 15'h0;
    qa.push_back(xa); qb.push_back(xb); qt.push_back(tag);
    @(negedge clk);
    ph2 = 1'b1; wr_mode = mode; wr_addr = wa; wr_data = wd;
    rda_addr = ~aa; rdb_addr = ~ab;
    case (mode)
      2'b01:   nv = {xb[14:8], wd[7:0]};
      2'b10:   nv = {wd[14:8], xb[7:0]};
      2'b11:   nv = wd;
      default: nv = ref_mem[wa];
    endcase
    ref_mem[wa] = nv;
    @(negedge clk);
    ph2 = 1'b0; wr_mode = 2'b00; rda_en = 1'b0; rdb_en = 1'b0;
  endtask

  // Monitor: scoreboard pop after each P1 edge, hold check after P2 edge.
  initial begin
    logic ph_was;
    logic hold_due;
    logic [14:0] la, lb;
    string lt;
    hold_due = 1'b0;
    forever begin
      @(posedge clk);
      ph_was = ph2;
      @(negedge clk);
      if (!ph_was && qa.size() > 0) begin
        la = qa.pop_front(); lb = qb.pop_front(); lt = qt.pop_front();
        check({lt, " portA"}, rda_data, la);
        check({lt, " portB R11"}, {rdb_hi, rdb_lo}, lb);
        check("R11 hi field", {8'h0, rdb_hi}, {8'h0, lb[14:8]});
        hold_due = 1'b1;
      end else if (ph_was && hold_due) begin
        check("R3 hold A", rda_data, la);
        check("R3 hold B", {rdb_hi, rdb_lo}, lb);
        hold_due = 1'b0;
      end
    end
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_mem[i] = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset A", rda_data, 15'h0);
    check("R1 reset B", {rdb_hi, rdb_lo}, 15'h0);
    for (int i = 0; i < 8; i++)
      instr(1, 3'(i), 1, 3'(7 - i), 2'b00, 0, 0, 0, "R1 regs zero");
    // R7 R12: full writes to each address
    for (int i = 0; i < 8; i++)
      instr(0, 0, 0, 0, 2'b11, 3'(i), 15'h0A5A ^ 15'(i * 15'h1111), 0, "R7 write");
    for (int i = 0; i < 8; i++)
      instr(1, 3'(i), 1, 3'(i), 2'b00, 0, 0, 0, "R12 R2 readback");
    // R3: same-instruction read and overwrite
    instr(1, 3, 1, 3, 2'b11, 3, 15'h7FFF, 0, "R3 old operand");
    instr(1, 3, 0, 0, 2'b00, 0, 0, 0, "R3 new value");
    // R4: disabled ports
    instr(0, 3, 0, 3, 2'b00, 0, 0, 0, "R4 disabled");
    instr(1, 2, 0, 2, 2'b00, 0, 0, 0, "R4 B disabled");
    // R6: mode none with data present
    instr(0, 0, 0, 0, 2'b00, 4, 15'h1234, 0, "R6 no write");
    instr(1, 4, 0, 0, 2'b00, 0, 0, 0, "R6 readback");
    // R8: low byte write merging port B
    instr(0, 0, 1, 5, 2'b01, 5, 15'h00C3, 0, "R8 low write");
    instr(1, 5, 0, 0, 2'b00, 0, 0, 0, "R8 readback");
    // R9: upper bits write merging port B
    instr(0, 0, 1, 6, 2'b10, 6, 15'h2A00, 0, "R9 high write");
    instr(1, 6, 0, 0, 2'b00, 0, 0, 0, "R9 readback");
    // R10: partial writes with port B disabled
    instr(0, 0, 0, 1, 2'b01, 1, 15'h7F99, 0, "R10 low no B");
    instr(0, 0, 0, 2, 2'b10, 2, 15'h55AA, 0, "R10 high no B");
    instr(1, 1, 1, 2, 2'b00, 0, 0, 0, "R10 readback");
    // R5: write inputs during P1 ignored
    instr(0, 0, 0, 0, 2'b00, 7, 15'h0F0F, 1, "R5 p1 write");
    instr(1, 7, 1, 0, 2'b00, 0, 0, 0, "R5 readback");
    repeat (3) @(negedge clk);
    if (qa.size() != 0) begin
      n_fail++;
      $display("FAIL R2 scoreboard left %0d items, expected 0", qa.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule